// File: doc/BRIEF.md
# Serial Byte Receiver with Acknowledge Handshake

This block receives asynchronous serial frames on a single input line. A frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line is sampled with an oversample strike (`tick_i`) that a shared baud generator supplies. A start bit is accepted only if the line is still low at the middle of that bit. Each data bit is then sampled at its own middle. When the stop bit has been sampled, the byte moves into a holding buffer.

Software controls the block through individual strobe inputs. It arms and disarms reception with an enable bit. It confirms that it has taken the buffered byte by pulsing an acknowledge strobe. It clears the two interrupt factor flags with a write-one-to-clear strobe and a mask. Three sticky error flags report parity, framing and overrun faults. An overrun is caused by a frame that finishes while the previous byte has not yet been acknowledged. Only a disable write clears the error flags.

Top module: `serial_rx_hold`

## Requirements
- R1: After reset the receiver is disabled. The data buffer reads 0x00, and all error flags, factor flags and interrupt outputs are 0.
- R2: While the enable bit is 0, activity on the serial line has no effect: no byte is buffered and no flag changes. Writing 1 to the enable bit arms the receiver, which then waits for a start bit.
- R3: An armed receiver with parity mode none takes a frame of start(0), 8 data bits LSB first and stop(1). It places the byte in the buffer and sets the complete factor flag. The shift state moves only on cycles where `tick_i` is 1.
- R4: A low level that is high again when sampled at mid-start is rejected as a glitch. No byte is buffered and no flag is set.
- R5: A stop bit sampled low sets the framing error flag and the error factor flag. The byte is still buffered and the complete flag is still set.
- R6: `par_mode_i` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = none. With even or odd parity, a parity bit follows the data. A mismatch found at transfer sets the parity error flag and the error factor flag.
- R7: If a frame completes while the previous byte is still unacknowledged, the overrun error flag and the error factor flag are set. The complete flag is not set, and the buffer keeps the earlier byte.
- R8: A pulse on `ack_wr_i` marks the buffer as read. The next frame is then buffered normally, with no overrun.
- R9: Writing 0 to the enable bit clears the parity, overrun and framing flags and drops any frame in progress. The buffer and both factor flags are left unchanged.
- R10: `clr_wr_i` clears each factor flag whose mask bit is 1 (bit 0 = complete, bit 1 = error). If a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: `irq_done_o` is 1 exactly when `ie_done_i` and the complete flag are both 1. `irq_err_o` is 1 exactly when `ie_err_i` and the error flag are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversample strike, OSR per bit time |
| rx_i | input | 1 | Serial line, idles high |
| par_mode_i | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| ack_wr_i | input | 1 | Buffer-read acknowledge strobe |
| clr_wr_i | input | 1 | Factor flag clear strobe |
| clr_mask_i | input | 2 | Flags to clear: bit 0 complete, bit 1 error |
| ie_done_i | input | 1 | Complete interrupt enable |
| ie_err_i | input | 1 | Error interrupt enable |
| rx_en_o | output | 1 | Current enable bit |
| rx_data_o | output | 8 | Data buffer |
| err_parity_o | output | 1 | Sticky parity error |
| err_overrun_o | output | 1 | Sticky overrun error |
| err_frame_o | output | 1 | Sticky framing error |
| flag_done_o | output | 1 | Receive-complete factor flag |
| flag_err_o | output | 1 | Error factor flag |
| irq_done_o | output | 1 | Receive-complete interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The bench builds the receiver with OSR = 8 and a two-stage line synchronizer. It drives a strike on every other clock. With OSR = 8, a full frame lasts well under two hundred cycles, so overrun chains, parity in both polarities and framing faults all fit in a short run. The midpoint is still four strikes from the start edge, so a two-strike low pulse is long enough to be seen at the line and short enough to be rejected at mid-start.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam logic [1:0] PMODE_NONE = 2'd0;
    localparam logic [1:0] PMODE_EVEN = 2'd1;
    localparam logic [1:0] PMODE_ODD  = 2'd2;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              par_en_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bit_o,
    output logic              stop_ok_o
);
    localparam int CNT_W = (OSR > 2) ? $clog2(OSR) : 1;
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shift;
        logic              par;
        logic              stop_ok;
        logic              done;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        if (!en_i) begin
            fr_d.state = ST_IDLE;
            fr_d.cnt   = '0;
        end else if (tick_i) begin
            unique case (fr_q.state)
                ST_IDLE: begin
                    if (!rx_i) begin
                        fr_d.state = ST_START;
                        fr_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (fr_q.cnt == MID_CNT) begin
                        fr_d.cnt = '0;
                        if (!rx_i) begin
                            fr_d.state = ST_DATA;
                            fr_d.idx   = '0;
                        end else begin
                            fr_d.state = ST_IDLE;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (fr_q.cnt == LAST_CNT) begin
                        fr_d.cnt   = '0;
                        fr_d.shift = {rx_i, fr_q.shift[DATA_W-1:1]};
                        if (fr_q.idx == LAST_IDX) begin
                            fr_d.state = par_en_i ? ST_PAR : ST_STOP;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (fr_q.cnt == LAST_CNT) begin
                        fr_d.cnt   = '0;
                        fr_d.par   = rx_i;
                        fr_d.state = ST_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (fr_q.cnt == LAST_CNT) begin
                        fr_d.cnt     = '0;
                        fr_d.stop_ok = rx_i;
                        fr_d.done    = 1'b1;
                        fr_d.state   = ST_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: begin
                    fr_d.state = ST_IDLE;
                    fr_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign done_o    = fr_q.done;
    assign data_o    = fr_q.shift;
    assign par_bit_o = fr_q.par;
    assign stop_ok_o = fr_q.stop_ok;

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (fr_q.state == ST_IDLE));

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && en_i) |=> ($stable(fr_q.shift) && !fr_q.done));

    // R4
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && fr_q.state == ST_START && fr_q.cnt == MID_CNT && rx_i)
        |=> (fr_q.state == ST_IDLE && !fr_q.done));
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr_i,
    input  logic              en_wdata_i,
    input  logic              ack_wr_i,
    input  logic              clr_wr_i,
    input  logic [1:0]        clr_mask_i,
    input  logic              ie_done_i,
    input  logic              ie_err_i,
    input  logic [1:0]        par_mode_i,
    input  logic              frame_done_i,
    input  logic [DATA_W-1:0] frame_data_i,
    input  logic              frame_par_i,
    input  logic              frame_stop_ok_i,
    output logic              en_o,
    output logic              par_en_o,
    output logic [DATA_W-1:0] buf_o,
    output logic              per_o,
    output logic              oer_o,
    output logic              fer_o,
    output logic              fl_done_o,
    output logic              fl_err_o,
    output logic              irq_done_o,
    output logic              irq_err_o
);
    typedef struct packed {
        logic              en;
        logic              pend;
        logic [DATA_W-1:0] buffer;
        logic              per;
        logic              oer;
        logic              fer;
        logic              fl_done;
        logic              fl_err;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic disable_wr;
    logic take;
    logic still_pending;
    logic par_on;
    logic par_odd;
    logic par_bad;

    always_comb begin
        par_on        = (par_mode_i == PMODE_EVEN) || (par_mode_i == PMODE_ODD);
        par_odd       = (par_mode_i == PMODE_ODD);
        par_bad       = par_on && ((^{frame_data_i, frame_par_i}) != par_odd);
        disable_wr    = en_wr_i && !en_wdata_i;
        take          = frame_done_i && ct_q.en && !disable_wr;
        still_pending = ct_q.pend && !ack_wr_i;

        ct_d = ct_q;
        if (ack_wr_i) ct_d.pend = 1'b0;
        if (clr_wr_i && clr_mask_i[0]) ct_d.fl_done = 1'b0;
        if (clr_wr_i && clr_mask_i[1]) ct_d.fl_err  = 1'b0;

        if (take) begin
            if (still_pending) begin
                ct_d.oer    = 1'b1;
                ct_d.fl_err = 1'b1;
            end else begin
                ct_d.buffer  = frame_data_i;
                ct_d.pend    = 1'b1;
                ct_d.fl_done = 1'b1;
            end
            if (!frame_stop_ok_i) begin
                ct_d.fer    = 1'b1;
                ct_d.fl_err = 1'b1;
            end
            if (par_bad) begin
                ct_d.per    = 1'b1;
                ct_d.fl_err = 1'b1;
            end
        end

        if (en_wr_i) begin
            ct_d.en = en_wdata_i;
            if (!en_wdata_i) begin
                ct_d.per = 1'b0;
                ct_d.oer = 1'b0;
                ct_d.fer = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign en_o       = ct_q.en;
    assign par_en_o   = par_on;
    assign buf_o      = ct_q.buffer;
    assign per_o      = ct_q.per;
    assign oer_o      = ct_q.oer;
    assign fer_o      = ct_q.fer;
    assign fl_done_o  = ct_q.fl_done;
    assign fl_err_o   = ct_q.fl_err;
    assign irq_done_o = ie_done_i & ct_q.fl_done;
    assign irq_err_o  = ie_err_i & ct_q.fl_err;

    // R5
    frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && ct_q.en && !en_wr_i && !frame_stop_ok_i)
        |=> (ct_q.fer && ct_q.fl_err));

    // R7
    ovr_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && ct_q.en && !en_wr_i && ct_q.pend && !ack_wr_i)
        |=> (ct_q.oer && $stable(ct_q.buffer)));

    // R8
    ack_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && ct_q.en && !en_wr_i && ack_wr_i)
        |=> (ct_q.pend && ct_q.buffer == $past(frame_data_i)));

    // R9
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && !en_wdata_i) |=> (!ct_q.per && !ct_q.oer && !ct_q.fer && !ct_q.en));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && ct_q.en && !en_wr_i && (!ct_q.pend || ack_wr_i)
         && clr_wr_i && clr_mask_i[0]) |=> ct_q.fl_done);
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic [1:0]        par_mode_i,
    input  logic              en_wr_i,
    input  logic              en_wdata_i,
    input  logic              ack_wr_i,
    input  logic              clr_wr_i,
    input  logic [1:0]        clr_mask_i,
    input  logic              ie_done_i,
    input  logic              ie_err_i,
    output logic              rx_en_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              err_parity_o,
    output logic              err_overrun_o,
    output logic              err_frame_o,
    output logic              flag_done_o,
    output logic              flag_err_o,
    output logic              irq_done_o,
    output logic              irq_err_o
);
    logic              rx_s;
    logic              en_w;
    logic              par_en_w;
    logic              fr_done_w;
    logic [DATA_W-1:0] fr_data_w;
    logic              fr_par_w;
    logic              fr_stop_w;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            srx_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (rx_i),
                .q_o   (rx_s)
            );
        end else begin : g_nosync
            assign rx_s = rx_i;
        end
    endgenerate

    srx_framer #(.OSR(OSR), .DATA_W(DATA_W)) framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .tick_i    (tick_i),
        .rx_i      (rx_s),
        .par_en_i  (par_en_w),
        .done_o    (fr_done_w),
        .data_o    (fr_data_w),
        .par_bit_o (fr_par_w),
        .stop_ok_o (fr_stop_w)
    );

    srx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_wr_i         (en_wr_i),
        .en_wdata_i      (en_wdata_i),
        .ack_wr_i        (ack_wr_i),
        .clr_wr_i        (clr_wr_i),
        .clr_mask_i      (clr_mask_i),
        .ie_done_i       (ie_done_i),
        .ie_err_i        (ie_err_i),
        .par_mode_i      (par_mode_i),
        .frame_done_i    (fr_done_w),
        .frame_data_i    (fr_data_w),
        .frame_par_i     (fr_par_w),
        .frame_stop_ok_i (fr_stop_w),
        .en_o            (en_w),
        .par_en_o        (par_en_w),
        .buf_o           (rx_data_o),
        .per_o           (err_parity_o),
        .oer_o           (err_overrun_o),
        .fer_o           (err_frame_o),
        .fl_done_o       (flag_done_o),
        .fl_err_o        (flag_err_o),
        .irq_done_o      (irq_done_o),
        .irq_err_o       (irq_err_o)
    );

    assign rx_en_o = en_w;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rx_en_o && !flag_done_o && !flag_err_o && !irq_done_o && !irq_err_o));

    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_done_i && !ie_err_i) |-> (!irq_done_o && !irq_err_o));
endmodule

// File: tb/serial_rx_hold_tb_top.sv
`timescale 1ns/1ps
module serial_rx_hold_tb_top;
    localparam int OSR  = 8;
    localparam int TDIV = 2;
    localparam int BITC = OSR * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] par_mode = 2'd0;
    logic       en_wr = 1'b0, en_wdata = 1'b0, ack_wr = 1'b0, clr_wr = 1'b0;
    logic [1:0] clr_mask = 2'd0;
    logic       ie_done = 1'b0, ie_err = 1'b0;
    logic       rx_en;
    logic [7:0] rx_data;
    logic       e_par, e_ovr, e_frm, f_done, f_err, q_done, q_err;

    int checks = 0;
    int errors = 0;
    logic watch_set = 1'b0;
    logic seen_set = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) tick <= ~tick;
    always @(negedge clk) if (watch_set && f_done) seen_set <= 1'b1;

    serial_rx_hold #(.OSR(OSR), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx), .par_mode_i(par_mode),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .ack_wr_i(ack_wr), .clr_wr_i(clr_wr),
        .clr_mask_i(clr_mask), .ie_done_i(ie_done), .ie_err_i(ie_err),
        .rx_en_o(rx_en), .rx_data_o(rx_data), .err_parity_o(e_par), .err_overrun_o(e_ovr),
        .err_frame_o(e_frm), .flag_done_o(f_done), .flag_err_o(f_err),
        .irq_done_o(q_done), .irq_err_o(q_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack_wr = 1'b1;
        @(negedge clk); ack_wr = 1'b0;
    endtask

    task automatic do_clr(input logic [1:0] m);
        @(negedge clk); clr_wr = 1'b1; clr_mask = m;
        @(negedge clk); clr_wr = 1'b0; clr_mask = 2'd0;
    endtask

    task automatic line_bit(input logic v);
        @(negedge clk); rx = v;
        repeat (BITC - 1) @(negedge clk);
    endtask

    // mode 0 none, 1 even, 2 odd
    task automatic send_frame(input logic [7:0] d, input logic [1:0] m,
                              input logic bad_par, input logic stop_v);
        logic p;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (m == 2'd1 || m == 2'd2) begin
            p = (m == 2'd1) ? (^d) : ~(^d);
            line_bit(p ^ bad_par);
        end
        line_bit(stop_v);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic t_reset();
        check("R1 enable", rx_en, 0);
        check("R1 data", rx_data, 0);
        check("R1 errors", {e_par, e_ovr, e_frm}, 0);
        check("R1 flags", {f_done, f_err, q_done, q_err}, 0);
    endtask

    task automatic t_disabled();
        send_frame(8'h5A, 2'd0, 1'b0, 1'b1);
        check("R2 no buffer while off", rx_data, 0);
        check("R2 no flag while off", {f_done, f_err}, 0);
        write_en(1'b1);
        check("R2 armed", rx_en, 1);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 2'd0, 1'b0, 1'b1);
        check("R3 data A5", rx_data, 8'hA5);
        check("R3 done flag", f_done, 1);
        check("R3 no error", {f_err, e_frm, e_par, e_ovr}, 0);
        check("R11 irq masked", q_done, 0);
        @(negedge clk); ie_done = 1'b1; #1;
        check("R11 irq done", q_done, 1);
        do_clr(2'b01);
        check("R10 done cleared", f_done, 0);
        check("R11 irq follows flag", q_done, 0);
        do_ack();
        send_frame(8'h3E, 2'd0, 1'b0, 1'b1);
        check("R3 data 3E", rx_data, 8'h3E);
        do_ack();
        do_clr(2'b01);
    endtask

    task automatic t_glitch();
        @(negedge clk); rx = 1'b0;
        repeat (2 * TDIV) @(negedge clk);
        rx = 1'b1;
        repeat (4 * BITC) @(negedge clk);
        check("R4 glitch no done", f_done, 0);
        check("R4 glitch buffer kept", rx_data, 8'h3E);
        check("R4 glitch no error", {f_err, e_frm}, 0);
    endtask

    task automatic t_framing();
        send_frame(8'h3C, 2'd0, 1'b0, 1'b0);
        check("R5 framing flag", e_frm, 1);
        check("R5 error factor", f_err, 1);
        check("R5 data still moved", rx_data, 8'h3C);
        check("R5 done still set", f_done, 1);
        @(negedge clk); ie_err = 1'b1; #1;
        check("R11 irq err", q_err, 1);
        write_en(1'b0);
        check("R9 framing cleared", e_frm, 0);
        check("R9 error factor kept", f_err, 1);
        check("R9 buffer kept", rx_data, 8'h3C);
        do_clr(2'b11);
        check("R10 both cleared", {f_done, f_err}, 0);
        write_en(1'b1);
        do_ack();
    endtask

    task automatic t_parity();
        par_mode = 2'd1;
        send_frame(8'h0F, 2'd1, 1'b0, 1'b1);
        check("R6 even good data", rx_data, 8'h0F);
        check("R6 even good no error", {e_par, f_err}, 0);
        do_ack();
        send_frame(8'h01, 2'd1, 1'b1, 1'b1);
        check("R6 even bad", {e_par, f_err}, 2'b11);
        write_en(1'b0); write_en(1'b1); do_ack(); do_clr(2'b11);
        par_mode = 2'd2;
        send_frame(8'h80, 2'd2, 1'b0, 1'b1);
        check("R6 odd good", {e_par, f_err}, 0);
        check("R6 odd data", rx_data, 8'h80);
        do_ack();
        send_frame(8'h80, 2'd2, 1'b1, 1'b1);
        check("R6 odd bad", e_par, 1);
        write_en(1'b0); write_en(1'b1); do_ack(); do_clr(2'b11);
        par_mode = 2'd0;
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 2'd0, 1'b0, 1'b1);
        check("R7 first byte", rx_data, 8'h11);
        do_clr(2'b01);
        send_frame(8'h22, 2'd0, 1'b0, 1'b1);
        check("R7 overrun flag", e_ovr, 1);
        check("R7 error factor", f_err, 1);
        check("R7 done suppressed", f_done, 0);
        check("R7 buffer kept", rx_data, 8'h11);
        do_ack();
        send_frame(8'h33, 2'd0, 1'b0, 1'b1);
        check("R8 loaded after ack", rx_data, 8'h33);
        check("R8 done set", f_done, 1);
        check("R8 overrun sticky", e_ovr, 1);
        write_en(1'b0);
        check("R9 overrun cleared", e_ovr, 0);
        write_en(1'b1);
        do_ack();
        do_clr(2'b11);
    endtask

    task automatic t_set_wins();
        @(negedge clk); clr_wr = 1'b1; clr_mask = 2'b01; watch_set = 1'b1;
        send_frame(8'h6D, 2'd0, 1'b0, 1'b1);
        @(negedge clk); clr_wr = 1'b0; clr_mask = 2'd0; watch_set = 1'b0;
        check("R10 set beats clear", seen_set, 1);
        check("R10 data", rx_data, 8'h6D);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_basic();
        t_glitch();
        t_framing();
        t_parity();
        t_overrun();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule